// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Write Slave

This block is the write side of a byte-addressed serial memory that sits on a two-wire bus. A faster system clock samples the bus clock and data lines. The block recognises Start and Stop, matches a device select byte against a fixed type code and three strap inputs, and takes a two-byte address. It then gathers data bytes into a one-row page buffer and answers each byte through an open-drain pull-down enable.

A transaction ends in one of two ways. If Stop arrives in the clock slot right after a data byte's acknowledge, the buffered bytes go into the array during a timed internal write cycle, and `busy_o` is high for that cycle. A Stop anywhere else drops the transaction and writes nothing. A write-control input write-protects the array. While the internal write runs, the block ignores the bus completely.

The array can be read back through a plain combinational read port. The current internal address is visible on its own output.

Top module: `twi_ee_wr`

## Requirements
- R1: After reset, `busy_o` and `sda_oe_o` are low.
- R2: A select byte is acknowledged only when bits 7:4 are 1010, bits 3:1 equal `strap_i`, and bit 0 (read/write) is 0. Any other select byte gets no acknowledge, and the rest of that transaction is ignored.
- R3: Both address bytes are acknowledged. The high byte comes first. Only the low `MEM_AW` bits of the 16-bit address pick a location; the upper bits have no effect.
- R4: With `wc_i` low, every data byte is acknowledged. With `wc_i` high, every data byte gets no acknowledge, the array is not changed and no write cycle starts.
- R5: A write cycle starts only when Stop follows the acknowledge of a data byte, in the very next clock slot. A Stop right after the address, or part-way through a byte, leaves the array unchanged and `busy_o` low.
- R6: A write cycle holds `busy_o` high for exactly `TWR_CYC` system clocks.
- R7: While `busy_o` is high, `sda_oe_o` stays low and all bus activity is ignored, including a matching select byte.
- R8: Inside a row of 2^`PAGE_AW` bytes, only the low `PAGE_AW` address bits advance, and they wrap at the end of the row. A later byte that lands on a position already written in the same transaction replaces the earlier one.
- R9: Bytes of the row that the transaction did not write keep their old contents.
- R10: After a write cycle, `cur_addr_o` points to the position that follows the last byte written, within the same row.
- R11: The acknowledge pull-down is enabled only after the SCL falling edge that ends bit 8. It is low while bit 8 is high, and it is released after the falling edge that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved wired-AND level) |
| wc_i | input | 1 | Write control; high write-protects the array |
| strap_i | input | 3 | Address straps compared with select bits 3:1 |
| sda_oe_o | output | 1 | Enables the open-drain pull-down on SDA |
| busy_o | output | 1 | High during the internal write cycle |
| cur_addr_o | output | MEM_AW | Internal address counter |
| rd_addr_i | input | MEM_AW | Array inspection read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
The bench builds the block with `MEM_AW` = 9 and `PAGE_AW` = 5, which gives sixteen 32-byte rows. Random addresses therefore hit the same rows often, and row-local wrap and partial overwrite happen many times. With 16-bit random addresses, the seven ignored upper address bits are almost always nonzero. `TWR_CYC` = 300 makes the write cycle longer than a Start plus a full select byte, so a new transaction can be attempted entirely inside the busy window. Data bytes per transaction run past the row size, so runs of more than 32 bytes wrap onto positions already written.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA
  } prot_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/twi_ee_sync.sv
module twi_ee_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/twi_ee_cond.sv
module twi_ee_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_d;
  assign scl_fall_o = ~scl_s_i & scl_d;
  // data edges while the clock is held high
  assign start_o    = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d & ~sda_d & sda_s_i;
endmodule

// File: rtl/twi_ee_proto.sv
module twi_ee_proto
  import twi_ee_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       busy_i,
  input  logic       wc_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       addr_hi_we_o,
  output logic       addr_lo_we_o,
  output logic       byte_we_o,
  output logic [7:0] byte_o,
  output logic       clr_o,
  output logic       commit_o
);
  prot_st_e   st_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic       in_ack_q;
  logic       tenth_q;
  logic       oe_q;
  logic       dev_match;

  assign dev_match = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == strap_i) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      bit_cnt_q    <= '0;
      shreg_q      <= '0;
      in_ack_q     <= 1'b0;
      tenth_q      <= 1'b0;
      oe_q         <= 1'b0;
      addr_hi_we_o <= 1'b0;
      addr_lo_we_o <= 1'b0;
      byte_we_o    <= 1'b0;
      clr_o        <= 1'b0;
      commit_o     <= 1'b0;
    end else begin
      addr_hi_we_o <= 1'b0;
      addr_lo_we_o <= 1'b0;
      byte_we_o    <= 1'b0;
      clr_o        <= 1'b0;
      commit_o     <= 1'b0;
      if (busy_i) begin
        // deaf during the internal write
        st_q     <= ST_IDLE;
        oe_q     <= 1'b0;
        in_ack_q <= 1'b0;
        tenth_q  <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_DEV;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        tenth_q   <= 1'b0;
        oe_q      <= 1'b0;
        clr_o     <= 1'b1;
      end else if (stop_i) begin
        commit_o <= (st_q == ST_DATA) && tenth_q;
        st_q     <= ST_IDLE;
        oe_q     <= 1'b0;
        in_ack_q <= 1'b0;
        tenth_q  <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i) begin
          if (bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
        end else if (scl_fall_i) begin
          tenth_q <= 1'b0;
          if (bit_cnt_q == 4'd8) begin
            if (!in_ack_q) begin
              in_ack_q <= 1'b1;
              unique case (st_q)
                ST_DEV: begin
                  if (dev_match) oe_q <= 1'b1;
                  else           st_q <= ST_IDLE;
                end
                ST_AHI: begin
                  oe_q         <= 1'b1;
                  addr_hi_we_o <= 1'b1;
                end
                ST_ALO: begin
                  oe_q         <= 1'b1;
                  addr_lo_we_o <= 1'b1;
                end
                ST_DATA: begin
                  oe_q      <= !wc_i;
                  byte_we_o <= 1'b1;
                end
                default: st_q <= ST_IDLE;
              endcase
            end else begin
              in_ack_q  <= 1'b0;
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              tenth_q   <= (st_q == ST_DATA);
              unique case (st_q)
                ST_DEV:  st_q <= ST_AHI;
                ST_AHI:  st_q <= ST_ALO;
                ST_ALO:  st_q <= ST_DATA;
                ST_DATA: st_q <= ST_DATA;
                default: st_q <= ST_IDLE;
              endcase
            end
          end
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign byte_o   = shreg_q;
endmodule

// File: rtl/twi_ee_page.sv
module twi_ee_page #(
  parameter int unsigned MEM_AW  = 11,
  parameter int unsigned PAGE_AW = 5,
  parameter int unsigned TWR_CYC = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_hi_we_i,
  input  logic              addr_lo_we_i,
  input  logic              byte_we_i,
  input  logic [7:0]        byte_i,
  input  logic              wc_i,
  input  logic              clr_i,
  input  logic              commit_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [MEM_AW-1:0] cur_addr_o,
  output logic              busy_o,
  output logic              mem_we_o
);
  localparam int unsigned PAGE_N = 1 << PAGE_AW;
  localparam int unsigned ROW_AW = MEM_AW - PAGE_AW;
  localparam int unsigned MEM_N  = 1 << MEM_AW;
  localparam int unsigned TMR_W  = $clog2(TWR_CYC + 1);

  logic [7:0]         addr_hi_q;
  logic [ROW_AW-1:0]  row_q;
  logic [PAGE_AW-1:0] col_q;
  logic [PAGE_N-1:0]  valid_q;
  logic [7:0]         pbuf_q [PAGE_N];
  logic [7:0]         mem_q  [MEM_N];
  logic [TMR_W-1:0]   tmr_q;
  logic               run_q;
  logic [PAGE_AW-1:0] idx_q;
  logic               take_byte;

  assign take_byte = byte_we_i && !wc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_hi_q <= '0;
      row_q     <= '0;
      col_q     <= '0;
      valid_q   <= '0;
      tmr_q     <= '0;
      run_q     <= 1'b0;
      idx_q     <= '0;
    end else begin
      if (addr_hi_we_i) addr_hi_q <= byte_i;
      if (addr_lo_we_i) {row_q, col_q} <= MEM_AW'({addr_hi_q, byte_i});
      if (clr_i) valid_q <= '0;
      else if (take_byte) valid_q[col_q] <= 1'b1;
      if (byte_we_i) col_q <= col_q + 1'b1;
      if (commit_i && (|valid_q) && (tmr_q == '0)) begin
        tmr_q <= TMR_W'(TWR_CYC);
        run_q <= 1'b1;
        idx_q <= '0;
      end else begin
        if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
        if (run_q) begin
          idx_q <= idx_q + 1'b1;
          if (&idx_q) run_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_byte) pbuf_q[col_q] <= byte_i;
  end

  // one buffer slot per clock, masked by the valid bits
  assign mem_we_o = run_q && valid_q[idx_q];

  always_ff @(posedge clk_i) begin
    if (mem_we_o) mem_q[{row_q, idx_q}] <= pbuf_q[idx_q];
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign cur_addr_o = {row_q, col_q};
  assign busy_o     = (tmr_q != '0);
endmodule

// File: rtl/twi_ee_wr.sv
module twi_ee_wr #(
  parameter int unsigned MEM_AW  = 11,
  parameter int unsigned PAGE_AW = 5,
  parameter int unsigned TWR_CYC = 1000,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wc_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [MEM_AW-1:0] cur_addr_o,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [1:0] line_raw, line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       addr_hi_we, addr_lo_we, byte_we, clr, commit, mem_we;
  logic [7:0] rx_byte;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    twi_ee_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  twi_ee_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (line_s[1]),
    .sda_s_i   (line_s[0]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  twi_ee_proto u_proto (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_s_i     (line_s[0]),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .busy_i      (busy_o),
    .wc_i        (wc_i),
    .strap_i     (strap_i),
    .sda_oe_o    (sda_oe_o),
    .addr_hi_we_o(addr_hi_we),
    .addr_lo_we_o(addr_lo_we),
    .byte_we_o   (byte_we),
    .byte_o      (rx_byte),
    .clr_o       (clr),
    .commit_o    (commit)
  );

  twi_ee_page #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .TWR_CYC(TWR_CYC)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_hi_we_i(addr_hi_we),
    .addr_lo_we_i(addr_lo_we),
    .byte_we_i   (byte_we),
    .byte_i      (rx_byte),
    .wc_i        (wc_i),
    .clr_i       (clr),
    .commit_i    (commit),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .cur_addr_o  (cur_addr_o),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we)
  );
endmodule

// File: rtl/twi_ee_wr_chk.sv
module twi_ee_wr_chk #(
  parameter int unsigned TWR_CYC = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic sda_oe_o,
  input logic scl_fall,
  input logic stop_det,
  input logic commit,
  input logic mem_we
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 32'd1;
    else             busy_len_q <= '0;
  end

  p_deaf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  p_ack_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == TWR_CYC));

  p_busy_from_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit));

  p_commit_at_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $past(stop_det));

  p_write_in_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy_o);
endmodule

bind twi_ee_wr twi_ee_wr_chk #(.TWR_CYC(TWR_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .sda_oe_o(sda_oe_o),
  .scl_fall(scl_fall),
  .stop_det(stop_det),
  .commit  (commit),
  .mem_we  (mem_we)
);

// File: tb/twi_ee_wr_bench.sv
module twi_ee_wr_bench;
  localparam int unsigned B_MEM_AW  = 9;
  localparam int unsigned B_PAGE_AW = 5;
  localparam int unsigned B_TWR     = 300;
  localparam int unsigned MEM_N     = 1 << B_MEM_AW;
  localparam int unsigned PAGE_N    = 1 << B_PAGE_AW;
  localparam int          HP        = 6;
  localparam logic [2:0]  STRAP     = 3'b101;
  localparam logic [7:0]  GOOD_DEV  = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wc = 1'b0;
  logic sda_line;
  logic sda_oe, busy;
  logic [B_MEM_AW-1:0] cur_addr, rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, busy_cnt = 0;
  logic [7:0] tx_data [64];
  logic [7:0] model [MEM_N];
  bit         known [MEM_N];

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  twi_ee_wr #(.MEM_AW(B_MEM_AW), .PAGE_AW(B_PAGE_AW), .TWR_CYC(B_TWR)) u_twi_ee_wr (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .wc_i(wc),
    .strap_i(STRAP), .sda_oe_o(sda_oe), .busy_o(busy), .cur_addr_o(cur_addr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(HP); m_scl = 1'b1; wclk(HP);
    m_sda = 1'b0; wclk(HP); m_scl = 1'b0; wclk(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(HP); m_scl = 1'b1; wclk(HP);
    m_sda = 1'b1; wclk(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output bit oe_b8);
    oe_b8 = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; wclk(HP); m_scl = 1'b1; wclk(HP / 2);
      if (i == 0) oe_b8 = sda_oe;
      wclk(HP - HP / 2); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit oe_b8, output bit oe_late);
    send_bits(b, 8, oe_b8);
    m_sda = 1'b1; wclk(HP); m_scl = 1'b1; wclk(HP / 2);
    ack = sda_oe;
    wclk(HP - HP / 2); m_scl = 1'b0;
    wclk(5);
    oe_late = sda_oe;
  endtask

  task automatic verify_row(input int row, input string tag);
    for (int c = 0; c < PAGE_N; c++) begin
      int a;
      a = row * PAGE_N + c;
      if (known[a]) begin
        rd_addr = B_MEM_AW'(a);
        #1;
        chk(rd_data == model[a], tag, rd_data, model[a]);
      end
    end
  endtask

  // endk: 0 stop after ack, 1 stop in the middle of an extra byte
  task automatic run_tx(input logic [7:0] dev, input logic [15:0] addr, input int n,
                        input bit wc_v, input int endk, input bit no_wait);
    bit ack, b8, late, commit_exp;
    int row, col;
    logic [7:0] stage [PAGE_N];
    bit         sv [PAGE_N];
    row = int'(addr[B_MEM_AW-1:B_PAGE_AW]);
    col = int'(addr[B_PAGE_AW-1:0]);
    wc = wc_v;
    busy_cnt = 0;
    bus_start();
    send_byte(dev, ack, b8, late);
    chk(ack == (dev == GOOD_DEV), "R2 select ack", ack, dev == GOOD_DEV);
    if (!ack) begin
      bus_stop(); wclk(B_TWR + 40);
      chk(busy_cnt == 0, "R2 no cycle after refused select", busy_cnt, 0);
      return;
    end
    send_byte(addr[15:8], ack, b8, late);
    chk(ack, "R3 high address ack", ack, 1);
    send_byte(addr[7:0], ack, b8, late);
    chk(ack, "R3 low address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(tx_data[k], ack, b8, late);
      chk(ack == !wc_v, "R4 data ack vs write control", ack, !wc_v);
      chk(!b8 && !late, "R11 ack enable window", {b8, late}, 0);
    end
    if (endk == 1) begin
      send_bits(8'hA5, 4, b8);
    end
    bus_stop();
    commit_exp = (endk == 0) && !wc_v && (n > 0);
    if (commit_exp) begin
      for (int c = 0; c < PAGE_N; c++) sv[c] = 1'b0;
      for (int k = 0; k < n; k++) begin
        stage[(col + k) % PAGE_N] = tx_data[k];
        sv[(col + k) % PAGE_N] = 1'b1;
      end
      for (int c = 0; c < PAGE_N; c++) if (sv[c]) begin
        model[row * PAGE_N + c] = stage[c];
        known[row * PAGE_N + c] = 1'b1;
      end
    end
    if (no_wait) return;
    wclk(B_TWR + 40);
    if (commit_exp) begin
      chk(busy_cnt == B_TWR, "R6 busy length", busy_cnt, B_TWR);
      chk(int'(cur_addr) == row * PAGE_N + (col + n) % PAGE_N, "R10 next address",
          cur_addr, row * PAGE_N + (col + n) % PAGE_N);
    end else begin
      chk(busy_cnt == 0, "R5 no cycle without proper stop", busy_cnt, 0);
    end
    verify_row(row, "R9 row contents (R8 wrap)");
  endtask

  initial begin
    bit ack, b8, late;
    void'($urandom(32'd20240611));
    for (int a = 0; a < MEM_N; a++) begin
      known[a] = 1'b0;
      model[a] = '0;
    end
    wclk(5);
    chk(busy == 1'b0 && sda_oe == 1'b0, "R1 reset outputs", {busy, sda_oe}, 0);
    rst_n = 1'b1;
    wclk(5);
    chk(busy == 1'b0 && sda_oe == 1'b0, "R1 idle after reset", {busy, sda_oe}, 0);

    // full row
    for (int k = 0; k < 32; k++) tx_data[k] = 8'(k * 7 + 1);
    run_tx(GOOD_DEV, 16'h0060, 32, 1'b0, 0, 1'b0);
    // partial across the row end
    for (int k = 0; k < 4; k++) tx_data[k] = 8'(8'hC0 + k);
    run_tx(GOOD_DEV, 16'h007E, 4, 1'b0, 0, 1'b0);
    // overrun: 34 bytes from col 5, last two overwrite cols 5 and 6 (R8)
    for (int k = 0; k < 34; k++) tx_data[k] = 8'(8'h40 + k);
    run_tx(GOOD_DEV, 16'h0065, 34, 1'b0, 0, 1'b0);
    // select mismatches (R2)
    run_tx({4'b1010, 3'b100, 1'b0}, 16'h0060, 2, 1'b0, 0, 1'b0);
    run_tx({4'b1011, STRAP, 1'b0}, 16'h0060, 2, 1'b0, 0, 1'b0);
    run_tx({4'b1010, STRAP, 1'b1}, 16'h0060, 2, 1'b0, 0, 1'b0);
    // write protected (R4)
    for (int k = 0; k < 3; k++) tx_data[k] = 8'hEE;
    run_tx(GOOD_DEV, 16'h0061, 3, 1'b1, 0, 1'b0);
    // stop after address, stop mid-byte (R5)
    run_tx(GOOD_DEV, 16'h0062, 0, 1'b0, 0, 1'b0);
    run_tx(GOOD_DEV, 16'h0062, 2, 1'b0, 1, 1'b0);
    // upper address bits ignored (R3)
    tx_data[0] = 8'h5A;
    run_tx(GOOD_DEV, 16'hFEAA, 1, 1'b0, 0, 1'b0);
    rd_addr = B_MEM_AW'(9'h0AA);
    #1;
    chk(rd_data == 8'h5A, "R3 upper bits dropped", rd_data, 8'h5A);
    // deaf while busy (R7)
    tx_data[0] = 8'h99;
    run_tx(GOOD_DEV, 16'h0100, 1, 1'b0, 0, 1'b1);
    chk(busy == 1'b1, "R7 busy during cycle", busy, 1);
    bus_start();
    send_byte(GOOD_DEV, ack, b8, late);
    chk(!ack, "R7 select ignored while busy", ack, 0);
    bus_stop();
    wclk(B_TWR + 40);
    chk(busy == 1'b0, "R6 busy drops", busy, 0);
    verify_row(8, "R7 row after ignored access");

    // random mix
    for (int it = 0; it < 14; it++) begin
      logic [7:0] dev;
      logic [15:0] ad;
      int n, endk;
      bit wcv;
      dev  = ($urandom % 7 == 0) ? {4'b1010, ~STRAP, 1'b0} : GOOD_DEV;
      ad   = 16'($urandom);
      n    = 1 + int'($urandom % 36);
      wcv  = ($urandom % 5 == 0);
      endk = ($urandom % 6 == 0) ? 1 : 0;
      for (int k = 0; k < n; k++) tx_data[k] = 8'($urandom);
      run_tx(dev, ad, n, wcv, endk, 1'b0);
    end
    summary();
  end
endmodule